// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is one eight-line slice of an interrupt controller. Each request input is latched into a pending register, either on a rising edge or as a live level, chosen per line. A mask register hides lines. An in-service register records the lines whose handlers are running. The slice finds the best pending, unmasked line. Priority is counted from a movable base line, so the base line ranks highest and the line just below it ranks lowest. The interrupt output is raised only when that line strictly outranks every line in service.

The consumer pulses an acknowledge strobe to take the offered line. It ends handlers with a command strobe that carries an opcode and a line number. Three configuration levels select automatic end-of-interrupt, rotation on automatic end-of-interrupt, and nested-cascade handling. The nested-cascade mode applies only when the slice is built as a master.

Top module: `irq_resolver`

## Requirements
- R1: While `rst_n` is low, and after it is released with all inputs low, `irq_out` is 0 and `irq_line` is 0. Reset clears the pending, previous-level, mask and in-service state and sets the base to line 0.
- R2: On an edge line (`trig_level` bit = 0), the pending bit is set only by a low-to-high change of `req_in`. An input held high does not set it again after an acknowledge, and a falling input does not clear it.
- R3: On a level line (`trig_level` bit = 1), the pending bit follows `req_in` at each clock edge.
- R4: Priority index p selects line (p + base) mod 8, and index 0 ranks highest. `irq_line` is the best pending unmasked line when `irq_out` is 1, and 0 otherwise.
- R5: A line whose mask bit is 1 never raises `irq_out`. The mask loads from `mask_din` when `mask_we` is 1.
- R6: `irq_out` is 1 only when the best pending unmasked index is strictly smaller than the best in-service index. An empty set counts as index 8.
- R7: `ack` while `irq_out` is 1, with automatic end-of-interrupt off, sets the in-service bit of `irq_line`. It clears that line's pending bit only for an edge line; a level line stays pending.
- R8: With `cfg_auto_eoi` = 1, an acknowledge sets no in-service bit. If `cfg_rot_aeoi` is also 1, the base becomes `irq_line` + 1 (mod 8).
- R9: `cmd_op` = 1 clears the in-service bit of highest priority. `cmd_op` = 2 does the same and also loads the base with that line + 1.
- R10: `cmd_op` = 3 clears the in-service bit of `cmd_line`. `cmd_op` = 4 does the same and also loads the base with `cmd_line` + 1.
- R11: `cmd_op` = 5 loads the base with (`cmd_line` + 1) mod 8. `cmd_op` = 0 does nothing. Commands act only when `cmd_valid` is 1.
- R12: In a master slice with `cfg_nested` = 1, in-service bit 2 is ignored when the current in-service priority is worked out.
- R13: `irq_out` and `irq_line` are combinational from the registered state. They reflect a change in the first cycle after the clock edge that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released upstream |
| req_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line trigger select: 1 level, 0 edge |
| mask_we | input | 1 | Mask load strobe |
| mask_din | input | 8 | Mask value; 1 hides the line |
| ack | input | 1 | Acknowledge strobe |
| cmd_valid | input | 1 | End-of-interrupt / priority command strobe |
| cmd_op | input | 3 | Command opcode (0 none, 1–5 as in R9–R11) |
| cmd_line | input | 3 | Line operand of the command |
| cfg_auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| cfg_rot_aeoi | input | 1 | Rotate base on automatic end-of-interrupt |
| cfg_nested | input | 1 | Nested-cascade mode (master slice only) |
| irq_out | output | 1 | Interrupt request to the consumer |
| irq_line | output | 3 | Line being offered |

## Verification
All state changes land on one clock edge, and the outputs follow from that state with no further register. A stimulus applied before edge k therefore shows at the outputs in the cycle after edge k. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Every vector then checks the result of the edge that consumed its inputs. The in-service state and the base are not visible at the ports. The sequences are arranged so that each acknowledge, command or rotation changes which line, if any, is offered next.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned LW    = $clog2(LINES);

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_EOI_TOP    = 3'd1,
    OP_EOI_TOP_RT = 3'd2,
    OP_EOI_LINE   = 3'd3,
    OP_EOI_LINE_RT= 3'd4,
    OP_SET_BASE   = 3'd5
  } cmd_op_e;
endpackage

// File: rtl/irq_rot_pick.sv
module irq_rot_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  input  logic [LW-1:0] base,
  output logic [LW:0]   idx,
  output logic [LW-1:0] line,
  output logic          found
);
  localparam logic [LW:0] NONE = LW'(0) | (LW+1)'(N);

  logic [N-1:0] rot;

  for (genvar p = 0; p < N; p++) begin : g_rot
    assign rot[p] = bits[LW'(p) + base];
  end

  always_comb begin
    idx = NONE;
    for (int p = N - 1; p >= 0; p--) begin
      if (rot[p]) idx = (LW+1)'(p);
    end
  end

  assign found = |bits;
  assign line  = idx[LW-1:0] + base;
endmodule

// File: rtl/irq_trig_latch.sv
module irq_trig_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] trig_level,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] prev_q, prev_d, pend_d;

  always_comb begin
    prev_d = req_in;
    for (int i = 0; i < N; i++) begin
      if (trig_level[i]) pend_d[i] = req_in[i];
      else               pend_d[i] = (pend_q[i] | (req_in[i] & ~prev_q[i])) & ~ack_clr[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_d;
      prev_q <= prev_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2: an edge line becomes pending only after its input was high
    a_r2_edge_sets_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_level[i] && $rose(pend_q[i])) |-> $past(req_in[i]));
    // R3: a level line tracks its input
    a_r3_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      trig_level[i] |=> (pend_q[i] == $past(req_in[i])));
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned N         = LINES,
  parameter bit          IS_MASTER = 1'b1,
  parameter int unsigned CASC_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_in,
  input  logic [N-1:0]         trig_level,
  input  logic                 mask_we,
  input  logic [N-1:0]         mask_din,
  input  logic                 ack,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [$clog2(N)-1:0] cmd_line,
  input  logic                 cfg_auto_eoi,
  input  logic                 cfg_rot_aeoi,
  input  logic                 cfg_nested,
  output logic                 irq_out,
  output logic [$clog2(N)-1:0] irq_line
);
  localparam int unsigned W = $clog2(N);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASC_LINE;

  logic [N-1:0] pend_q, imr_q, imr_d, isr_q, isr_d, isr_view, ack_clr, isr_clr, live;
  logic [W-1:0] base_q, base_d;
  logic         imr_en, isr_en, base_en, take;
  logic [W:0]   req_idx, view_idx, top_idx;
  logic [W-1:0] req_ln, view_ln, top_ln;
  logic         req_any, view_any, top_any;
  cmd_op_e      op;

  assign op       = cmd_valid ? cmd_op_e'(cmd_op) : OP_NONE;
  assign live     = pend_q & ~imr_q;
  assign isr_view = (IS_MASTER && cfg_nested) ? (isr_q & ~CASC_BIT) : isr_q;

  irq_trig_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
    .ack_clr(ack_clr), .pend_q(pend_q));

  irq_rot_pick #(.N(N), .LW(W)) u_pick_req (
    .bits(live), .base(base_q), .idx(req_idx), .line(req_ln), .found(req_any));
  irq_rot_pick #(.N(N), .LW(W)) u_pick_view (
    .bits(isr_view), .base(base_q), .idx(view_idx), .line(view_ln), .found(view_any));
  irq_rot_pick #(.N(N), .LW(W)) u_pick_top (
    .bits(isr_q), .base(base_q), .idx(top_idx), .line(top_ln), .found(top_any));

  assign irq_out  = req_any && (req_idx < view_idx);
  assign irq_line = irq_out ? req_ln : '0;
  assign take     = ack && irq_out;
  assign ack_clr  = take ? (N'(1) << req_ln) : '0;

  always_comb begin
    isr_clr = '0;
    base_d  = base_q;
    base_en = 1'b0;
    if (take && cfg_auto_eoi && cfg_rot_aeoi) begin
      base_d  = req_ln + W'(1);
      base_en = 1'b1;
    end
    unique case (op)
      OP_EOI_TOP, OP_EOI_TOP_RT: begin
        if (top_any) begin
          isr_clr = N'(1) << top_ln;
          if (op == OP_EOI_TOP_RT) begin
            base_d  = top_ln + W'(1);
            base_en = 1'b1;
          end
        end
      end
      OP_EOI_LINE, OP_EOI_LINE_RT: begin
        isr_clr = N'(1) << cmd_line;
        if (op == OP_EOI_LINE_RT) begin
          base_d  = cmd_line + W'(1);
          base_en = 1'b1;
        end
      end
      OP_SET_BASE: begin
        base_d  = cmd_line + W'(1);
        base_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    isr_d  = (isr_q & ~isr_clr) | ((take && !cfg_auto_eoi) ? ack_clr : '0);
    isr_en = (isr_clr != '0) || (take && !cfg_auto_eoi);
    imr_d  = mask_din;
    imr_en = mask_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      imr_q  <= '0;
      base_q <= '0;
    end else begin
      if (isr_en)  isr_q  <= isr_d;
      if (imr_en)  imr_q  <= imr_d;
      if (base_en) base_q <= base_d;
    end
  end

  // R6: an offered line is pending and unmasked
  a_r6_offer_is_live: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> live[irq_line]);
  // R7: acknowledge without automatic end puts the line in service
  a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cfg_auto_eoi && !cmd_valid) |=> isr_q[$past(irq_line)]);
  // R8: automatic end leaves the in-service bit clear
  a_r8_aeoi_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cfg_auto_eoi && !isr_q[irq_line] && !cmd_valid) |=> !isr_q[$past(irq_line)]);
  // R9: non-specific end removes exactly one in-service bit
  a_r9_top_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2) && isr_q != '0 && !ack)
      |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
  // R10: specific end clears the named line
  a_r10_line_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4) && !ack) |=> !isr_q[$past(cmd_line)]);
endmodule

// File: tb/sim_irq_resolver.sv
module sim_irq_resolver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_in, trig_level, mask_din;
  logic       mask_we, ack, cmd_valid, cfg_auto_eoi, cfg_rot_aeoi, cfg_nested;
  logic [2:0] cmd_op, cmd_line;
  logic       irq_out;
  logic [2:0] irq_line;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_resolver u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
    .mask_we(mask_we), .mask_din(mask_din), .ack(ack), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_line(cmd_line), .cfg_auto_eoi(cfg_auto_eoi),
    .cfg_rot_aeoi(cfg_rot_aeoi), .cfg_nested(cfg_nested),
    .irq_out(irq_out), .irq_line(irq_line));

  // {req id, req_in, trig_level, mask_we, mask_din, ack, op, line, {aeoi,rot,nested}, exp irq, exp line}
  localparam int NV = 35;
  localparam logic [42:0] VEC [NV] = '{
    {4'd1 ,8'h00,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b0,3'd0}, // R1 idle
    {4'd2 ,8'h08,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b1,3'd3}, // R2 rise, R13 next cycle
    {4'd7 ,8'h08,8'h00,1'b0,8'h00,1'b1,3'd0,3'd0,3'b000,1'b0,3'd0}, // R7 ack
    {4'd2 ,8'h08,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b0,3'd0}, // R2 held high
    {4'd6 ,8'h0A,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b1,3'd1}, // R6 nests
    {4'd7 ,8'h0A,8'h00,1'b0,8'h00,1'b1,3'd0,3'd0,3'b000,1'b0,3'd0}, // R7
    {4'd6 ,8'h1A,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b0,3'd0}, // R6 lower blocked
    {4'd9 ,8'h1A,8'h00,1'b0,8'h00,1'b0,3'd1,3'd0,3'b000,1'b0,3'd0}, // R9 clears line 1
    {4'd9 ,8'h1A,8'h00,1'b0,8'h00,1'b0,3'd1,3'd0,3'b000,1'b1,3'd4}, // R9 clears line 3
    {4'd2 ,8'h00,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b1,3'd4}, // R2 fall keeps
    {4'd11,8'h40,8'h00,1'b0,8'h00,1'b0,3'd5,3'd4,3'b000,1'b1,3'd6}, // R11 base 5
    {4'd7 ,8'h40,8'h00,1'b0,8'h00,1'b1,3'd0,3'd0,3'b000,1'b0,3'd0}, // R7
    {4'd10,8'h40,8'h00,1'b0,8'h00,1'b0,3'd4,3'd6,3'b000,1'b1,3'd4}, // R10 base 7
    {4'd13,8'h40,8'h00,1'b1,8'h10,1'b0,3'd0,3'd0,3'b000,1'b0,3'd0}, // R13 / R5 mask
    {4'd5 ,8'h41,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b1,3'd0}, // R5
    {4'd4 ,8'h41,8'h00,1'b1,8'h00,1'b0,3'd0,3'd0,3'b000,1'b1,3'd0}, // R4 base 7 order
    {4'd8 ,8'h41,8'h00,1'b0,8'h00,1'b1,3'd0,3'd0,3'b100,1'b1,3'd4}, // R8 no isr
    {4'd8 ,8'h41,8'h00,1'b0,8'h00,1'b1,3'd0,3'd0,3'b110,1'b0,3'd0}, // R8 rotate to 5
    {4'd2 ,8'h00,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b0,3'd0}, // R2
    {4'd8 ,8'h30,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b1,3'd5}, // R8 base proved 5
    {4'd7 ,8'h30,8'h00,1'b0,8'h00,1'b1,3'd0,3'd0,3'b000,1'b0,3'd0}, // R7
    {4'd10,8'h30,8'h00,1'b0,8'h00,1'b0,3'd3,3'd5,3'b000,1'b1,3'd4}, // R10
    {4'd7 ,8'h30,8'h00,1'b0,8'h00,1'b1,3'd0,3'd0,3'b000,1'b0,3'd0}, // R7
    {4'd3 ,8'h34,8'h04,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b1,3'd2}, // R3 level high
    {4'd7 ,8'h34,8'h04,1'b0,8'h00,1'b1,3'd0,3'd0,3'b000,1'b0,3'd0}, // R7 level stays
    {4'd3 ,8'h30,8'h04,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b0,3'd0}, // R3 level low
    {4'd9 ,8'h30,8'h04,1'b0,8'h00,1'b0,3'd2,3'd0,3'b000,1'b0,3'd0}, // R9 rotate to 3
    {4'd9 ,8'h34,8'h04,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b0,3'd0}, // R9 base 3 blocks
    {4'd10,8'h30,8'h04,1'b0,8'h00,1'b0,3'd3,3'd4,3'b000,1'b0,3'd0}, // R10
    {4'd11,8'h30,8'h00,1'b0,8'h00,1'b0,3'd5,3'd7,3'b000,1'b0,3'd0}, // R11 base 0
    {4'd4 ,8'h34,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b1,3'd2}, // R4
    {4'd7 ,8'h34,8'h00,1'b0,8'h00,1'b1,3'd0,3'd0,3'b000,1'b0,3'd0}, // R7
    {4'd12,8'h30,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b0,3'd0}, // R12
    {4'd12,8'h34,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b001,1'b1,3'd2}, // R12 nested ignores bit 2
    {4'd12,8'h34,8'h00,1'b0,8'h00,1'b0,3'd0,3'd0,3'b000,1'b0,3'd0}  // R12 off blocks
  };

  task automatic check(input int rid, input logic eirq, input logic [2:0] eln);
    checks++;
    if (irq_out !== eirq || irq_line !== eln) begin
      errors++;
      $display("FAIL R%0d: irq_out=%0b irq_line=%0d expected irq_out=%0b irq_line=%0d",
               rid, irq_out, irq_line, eirq, eln);
    end
  endtask

  task automatic idle_inputs();
    req_in = '0; trig_level = '0; mask_we = 0; mask_din = '0; ack = 0;
    cmd_valid = 0; cmd_op = '0; cmd_line = '0;
    cfg_auto_eoi = 0; cfg_rot_aeoi = 0; cfg_nested = 0;
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(1, 1'b0, 3'd0); // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      req_in       = VEC[k][38:31];
      trig_level   = VEC[k][30:23];
      mask_we      = VEC[k][22];
      mask_din     = VEC[k][21:14];
      ack          = VEC[k][13];
      cmd_op       = VEC[k][12:10];
      cmd_valid    = (VEC[k][12:10] != 3'd0);
      cmd_line     = VEC[k][9:7];
      cfg_auto_eoi = VEC[k][6];
      cfg_rot_aeoi = VEC[k][5];
      cfg_nested   = VEC[k][4];
      @(negedge clk);
      check(int'(VEC[k][42:39]), VEC[k][3], VEC[k][2:0]);
    end
    // R1: reset mid-run with a line pending and in service
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 3'd0);
    idle_inputs();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 1'b0, 3'd0);
    // R1: mask and base back to defaults -> line 0 offered; R4 line 0 beats line 7
    req_in = 8'h81;
    @(negedge clk);
    check(1, 1'b1, 3'd0);
    // R11: command strobe low means no base change
    cmd_op = 3'd5; cmd_line = 3'd6; cmd_valid = 1'b0;
    @(negedge clk);
    check(11, 1'b1, 3'd0);
    cmd_valid = 1'b1;
    @(negedge clk);
    check(11, 1'b1, 3'd7); // base 7: line 7 first
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule